// File: doc/BRIEF.md
# Averaging ADC Step Sequencer

The block runs a list of conversion steps against a multiplexed successive-approximation converter. It holds up to eight steps. Each step has its own settings: an input channel, an open delay, a sample delay and an averaging count. For each step the block first puts the step's channel on the mux select. It then idles for the open delay, which is paid once per step. After that it repeats two phases once per averaged sample: a sample-and-hold window, then a fixed 13-cycle conversion. The converter word is captured in the last cycle of each conversion.

The captured words of a step are summed and scaled back to 12 bits. The block presents the result for one clock, tagged with its step index and channel. Software-side logic programs the steps through a narrow write port. A start pulse launches a pass over steps 0 to `last_step_i`. In one-shot mode the pass runs once. In continuous mode it wraps back to step 0 with no gap, for as long as `cont_i` is high at the end of a pass.

Top module: `adc_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `sample_o`, `capture_o` and `res_valid_o` are low.
- R2: A write with `cfg_we_i` high sets one field of step `cfg_step_i`, chosen by `cfg_field_i`. The codes are: 0 channel (`cfg_wdata_i[2:0]`), 1 open delay (`[17:0]`), 2 sample delay (`[7:0]`), 3 averaging count (`[17:0]`). A step copies its settings when it starts, so a write made while that step runs first takes effect at its next start.
- R3: From the first cycle of a step, `mux_sel_o` carries the step's channel. `sample_o` stays low for the first open-delay cycles of the step, and this delay is paid once per step.
- R4: Each sample window holds `sample_o` high for sample delay + 2 consecutive cycles.
- R5: Every window is followed by 13 conversion cycles. `capture_o` is high in the 13th of these, and `adc_data_i` is taken at the end of that cycle.
- R6: A step lasts open delay + avg × (15 + sample delay) cycles. With all fields at minimum a step takes 15 cycles, and a full eight-step pass takes 120 cycles.
- R7: An averaging value other than 1, 2, 4, 8 or 16 is treated as 1.
- R8: The 12-bit samples of a step are summed in 16 bits. The sum is shifted right by log2(avg). The result appears on `res_data_o` for one cycle with `res_valid_o` high, one cycle after the step's last capture, and `res_step_o`/`res_chan_o` give the step index and channel.
- R9: Steps run in order from 0 to `last_step_i`. In one-shot mode the pass ends after that step.
- R10: If `cont_i` is high at the last capture of the final step, step 0 starts in the very next cycle. Otherwise the pass ends.
- R11: `busy_o` rises in the first cycle of step 0 and falls in the cycle after the final capture of the sequence. `start_i` has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_step_i | input | 3 | Step addressed by the write |
| cfg_field_i | input | 2 | Field code (see R2) |
| cfg_wdata_i | input | 18 | Write data |
| start_i | input | 1 | Launch a pass when idle |
| cont_i | input | 1 | Continuous mode when high |
| last_step_i | input | 3 | Index of the final step of a pass |
| adc_data_i | input | 12 | Converter result word |
| mux_sel_o | output | 3 | Input mux select |
| sample_o | output | 1 | Sample-and-hold window |
| capture_o | output | 1 | Converter word is taken this cycle |
| busy_o | output | 1 | Sequence running |
| res_valid_o | output | 1 | Averaged result valid |
| res_data_o | output | 12 | Averaged result |
| res_step_o | output | 3 | Step index of the result |
| res_chan_o | output | 3 | Channel of the result |

## Verification
The overflow check on the sum relies on at most 16 samples per step, each no wider than 12 bits. The bench also exercises the full-scale input of 4095 at an averaging count of 16. The wrap and busy properties assume that `last_step_i` is held steady during a pass. The bench changes it only while the block is idle, and it drops `cont_i` only from its own negedge process.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W    = 3;
  localparam int OD_W    = 18;
  localparam int SD_W    = 8;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    F_CHAN = 2'd0,
    F_OPEN = 2'd1,
    F_SAMP = 2'd2,
    F_AVG  = 2'd3
  } field_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_SAMP,
    ST_CONV
  } state_e;

  typedef struct packed {
    logic [CH_W-1:0]    chan;
    logic [OD_W-1:0]    open_dly;
    logic [SD_W-1:0]    samp_dly;
    logic [SHIFT_W-1:0] avg_shift;
  } step_cfg_t;

  // non power-of-two counts fall back to a single sample
  function automatic logic [SHIFT_W-1:0] avg_to_shift(input logic [OD_W-1:0] v);
    case (v)
      18'd2:   return 3'd1;
      18'd4:   return 3'd2;
      18'd8:   return 3'd3;
      18'd16:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS = 8,
  parameter int STEP_W  = $clog2(N_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STEP_W-1:0] wr_step_i,
  input  logic [1:0]        field_i,
  input  logic [OD_W-1:0]   wdata_i,
  input  logic [STEP_W-1:0] rd_step_i,
  output step_cfg_t         cfg_o
);
  step_cfg_t cfg_q [N_STEPS];

  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= '0;
      end else if (we_i && wr_step_i == STEP_W'(g)) begin
        case (field_e'(field_i))
          F_CHAN: cfg_q[g].chan      <= wdata_i[CH_W-1:0];
          F_OPEN: cfg_q[g].open_dly  <= wdata_i;
          F_SAMP: cfg_q[g].samp_dly  <= wdata_i[SD_W-1:0];
          F_AVG:  cfg_q[g].avg_shift <= avg_to_shift(wdata_i);
          default: ;
        endcase
      end
    end

    a_r7_shift_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[g].avg_shift <= 3'd4);
  end

  assign cfg_o = cfg_q[rd_step_i];
endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum #(
  parameter int DATA_W  = 12,
  parameter int ACC_W   = 16,
  parameter int SHIFT_W = 3,
  parameter int TAG_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic               first_i,
  input  logic               last_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [TAG_W-1:0]   tag_o
);
  logic [ACC_W-1:0] acc_q, sum;

  assign sum = (first_i ? '0 : acc_q) + ACC_W'(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= cap_i && last_i;
      if (cap_i) acc_q <= sum;
      if (cap_i && last_i) begin
        data_o <= DATA_W'(sum >> shift_i);
        tag_o  <= tag_i;
      end
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !first_i) |-> ((({1'b0, acc_q} + (ACC_W+1)'(data_i)) >> ACC_W) == '0));

  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS     = 8,
  parameter int STEP_W      = $clog2(N_STEPS),
  parameter int CONV_CYC    = 13,
  parameter int MAX_AVG_LOG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [STEP_W-1:0] last_step_i,
  input  step_cfg_t         cfg_i,
  output logic [STEP_W-1:0] rd_step_o,
  output logic [STEP_W-1:0] step_o,
  output step_cfg_t         cur_o,
  output logic              busy_o,
  output logic              sample_o,
  output logic              cap_o,
  output logic              first_o,
  output logic              last_o
);
  localparam int SCNT_W = MAX_AVG_LOG + 1;

  state_e            state_q, ent_state;
  logic [OD_W-1:0]   cnt_q, ent_cnt;
  step_cfg_t         cur_q;
  logic [STEP_W-1:0] step_q;
  logic [SCNT_W-1:0] scnt_q, scnt_last;
  logic              seq_end;

  assign scnt_last = SCNT_W'((1 << cur_q.avg_shift) - 1);
  assign seq_end   = step_q >= last_step_i;
  assign rd_step_o = (state_q == ST_IDLE || seq_end) ? '0 : step_q + 1'b1;
  assign cap_o     = (state_q == ST_CONV) && (cnt_q == '0);
  assign first_o   = scnt_q == '0;
  assign last_o    = scnt_q == scnt_last;
  assign busy_o    = state_q != ST_IDLE;
  assign sample_o  = state_q == ST_SAMP;
  assign step_o    = step_q;
  assign cur_o     = cur_q;

  // phase entered when a step starts
  always_comb begin
    if (cfg_i.open_dly != '0) begin
      ent_state = ST_OPEN;
      ent_cnt   = cfg_i.open_dly - 1'b1;
    end else begin
      ent_state = ST_SAMP;
      ent_cnt   = OD_W'(cfg_i.samp_dly) + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      step_q  <= '0;
      scnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          step_q  <= rd_step_o;
          cur_q   <= cfg_i;
          state_q <= ent_state;
          cnt_q   <= ent_cnt;
        end
        ST_OPEN: if (cnt_q == '0) begin
          state_q <= ST_SAMP;
          cnt_q   <= OD_W'(cur_q.samp_dly) + 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        ST_SAMP: if (cnt_q == '0) begin
          state_q <= ST_CONV;
          cnt_q   <= OD_W'(CONV_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_CONV: if (cnt_q == '0) begin
          if (!last_o) begin
            scnt_q  <= scnt_q + 1'b1;
            state_q <= ST_SAMP;
            cnt_q   <= OD_W'(cur_q.samp_dly) + 1'b1;
          end else begin
            scnt_q <= '0;
            if (seq_end && !cont_i) begin
              state_q <= ST_IDLE;
            end else begin
              step_q  <= rd_step_o;
              cur_q   <= cfg_i;
              state_q <= ent_state;
              cnt_q   <= ent_cnt;
            end
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMP && cnt_q != '0) |=> state_q == ST_SAMP);

  a_r5_cap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);

  a_r3_mux_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(cap_o && last_o)) |=> $stable(cur_q.chan));

  a_r11_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cap_o) |=> busy_o);

  a_r10_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && last_o && seq_end && cont_i) |=> (busy_o && step_q == '0));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS  = 8,
  parameter int DATA_W   = 12,
  parameter int ACC_W    = 16,
  parameter int CONV_CYC = 13,
  localparam int STEP_W  = $clog2(N_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [STEP_W-1:0] cfg_step_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [OD_W-1:0]   cfg_wdata_i,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [STEP_W-1:0] last_step_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic              sample_o,
  output logic              capture_o,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [STEP_W-1:0] res_step_o,
  output logic [CH_W-1:0]   res_chan_o
);
  localparam int TAG_W = STEP_W + CH_W;

  step_cfg_t         rd_cfg, cur_cfg;
  logic [STEP_W-1:0] rd_step, cur_step;
  logic              first, last;
  logic [TAG_W-1:0]  tag_out;

  adc_seq_regs #(.N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wr_step_i (cfg_step_i),
    .field_i   (cfg_field_i),
    .wdata_i   (cfg_wdata_i),
    .rd_step_i (rd_step),
    .cfg_o     (rd_cfg)
  );

  adc_seq_ctrl #(.N_STEPS(N_STEPS), .STEP_W(STEP_W), .CONV_CYC(CONV_CYC)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cont_i, .last_step_i,
    .cfg_i     (rd_cfg),
    .rd_step_o (rd_step),
    .step_o    (cur_step),
    .cur_o     (cur_cfg),
    .busy_o,
    .sample_o,
    .cap_o     (capture_o),
    .first_o   (first),
    .last_o    (last)
  );

  adc_seq_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .TAG_W(TAG_W)) u_accum (
    .clk_i, .rst_ni,
    .cap_i   (capture_o),
    .first_i (first),
    .last_i  (last),
    .shift_i (cur_cfg.avg_shift),
    .data_i  (adc_data_i),
    .tag_i   ({cur_step, cur_cfg.chan}),
    .valid_o (res_valid_o),
    .data_o  (res_data_o),
    .tag_o   (tag_out)
  );

  assign mux_sel_o  = cur_cfg.chan;
  assign res_step_o = tag_out[TAG_W-1:CH_W];
  assign res_chan_o = tag_out[CH_W-1:0];
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_step_i = '0;
  logic [1:0]  cfg_field_i = '0;
  logic [17:0] cfg_wdata_i = '0;
  logic        start_i = 1'b0;
  logic        cont_i = 1'b0;
  logic [2:0]  last_step_i = '0;
  logic [11:0] adc_data_i = '0;
  logic [2:0]  mux_sel_o, res_step_o, res_chan_o;
  logic        sample_o, capture_o, busy_o, res_valid_o;
  logic [11:0] res_data_o;

  adc_seq u_adc_seq (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc_total = 0;
  bit full_scale = 0;
  int m_ch[8], m_od[8], m_sd[8], m_avg[8];
  int r_cyc[64], r_val[64], r_step[64], r_chan[64];
  int n_res, samp_hi, caps, first_samp, busy_low, mux0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int n);
    return full_scale ? 4095 : (n * 733 + 91) % 4096;
  endfunction

  function automatic int lg2(input int a);
    int r = 0;
    while ((1 << r) < a) r++;
    return r;
  endfunction

  task automatic wr(input int s, input int f, input int v);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_step_i = 3'(s); cfg_field_i = 2'(f); cfg_wdata_i = 18'(v);
    @(negedge clk_i);
    cfg_we_i = 0;
    case (f)
      0: m_ch[s] = v % 8;
      1: m_od[s] = v;
      2: m_sd[s] = v % 256;
      default: m_avg[s] = (v == 1 || v == 2 || v == 4 || v == 8 || v == 16) ? v : 1;
    endcase
  endtask

  task automatic set_step(input int s, input int ch, input int od, input int sd, input int avg);
    wr(s, 0, ch); wr(s, 1, od); wr(s, 2, sd); wr(s, 3, avg);
  endtask

  // cont_drop < 0: one-shot; wr_at < 0: no write during the run
  task automatic run(input string vtag, input int last, input int cont_drop,
                     input int restart_at, input int wr_at, input int wr_step, input int wr_chan);
    int t, cb, e, s, es, ch, a, sm, tt;
    int x_cyc[64], x_val[64], x_step[64], x_chan[64];
    @(negedge clk_i);
    last_step_i = 3'(last); cont_i = (cont_drop >= 0); start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    n_res = 0; samp_hi = 0; caps = 0; first_samp = -1; busy_low = -1; mux0 = -1;
    for (int c = 0; c < 60000; c++) begin
      if (c == 0) mux0 = mux_sel_o;
      if (res_valid_o && n_res < 64) begin
        r_cyc[n_res] = c; r_val[n_res] = res_data_o;
        r_step[n_res] = res_step_o; r_chan[n_res] = res_chan_o; n_res++;
      end
      if (sample_o) begin samp_hi++; if (first_samp < 0) first_samp = c; end
      if (capture_o) begin adc_data_i = 12'(pat(caps)); caps++; end
      if (!busy_o && busy_low < 0) busy_low = c;
      if (c == cont_drop) cont_i = 0;
      start_i = (c == restart_at);
      cfg_we_i = (c == wr_at);
      if (c == wr_at) begin cfg_step_i = 3'(wr_step); cfg_field_i = 2'd0; cfg_wdata_i = 18'(wr_chan); end
      if (busy_low >= 0 && c >= busy_low + 3) break;
      @(negedge clk_i);
    end
    start_i = 0; cfg_we_i = 0; cont_i = 0;
    // expected schedule
    t = 0; cb = 0; e = 0; s = 0; es = 0;
    while (e < 60) begin
      ch = (wr_at >= 0 && s == wr_step && wr_at < t) ? wr_chan : m_ch[s];
      a = m_avg[s]; sm = 0;
      for (int i = 0; i < a; i++) sm += pat(cb + i);
      cb += a;
      tt = m_od[s] + a * (15 + m_sd[s]);
      t += tt;
      x_cyc[e] = t; x_val[e] = sm >> lg2(a); x_step[e] = s; x_chan[e] = ch; e++;
      es += a * (m_sd[s] + 2);
      if (s == last) begin
        if (t - 1 < cont_drop) s = 0; else break;
      end else s++;
    end
    chk(n_res == e, (cont_drop >= 0) ? "R10" : "R9", "result count", n_res, e);
    for (int i = 0; i < e && i < n_res; i++) begin
      chk(r_val[i] == x_val[i], vtag, "value", r_val[i], x_val[i]);
      chk(r_cyc[i] == x_cyc[i], "R6", "result cycle", r_cyc[i], x_cyc[i]);
      chk(r_step[i] == x_step[i], "R9", "step index", r_step[i], x_step[i]);
      chk(r_chan[i] == x_chan[i], (wr_at >= 0) ? "R2" : "R8", "channel", r_chan[i], x_chan[i]);
    end
    chk(busy_low == t, "R11", "busy end", busy_low, t);
    chk(samp_hi == es, "R4", "sample cycles", samp_hi, es);
    chk(caps == cb, "R5", "captures", caps, cb);
    chk(first_samp == m_od[0], "R3", "first sample", first_samp, m_od[0]);
    chk(mux0 == m_ch[0], "R3", "mux at step start", mux0, m_ch[0]);
    if (wr_at >= 0) m_ch[wr_step] = wr_chan;
  endtask

  always @(posedge clk_i) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc_total);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_ch[i] = 0; m_od[i] = 0; m_sd[i] = 0; m_avg[i] = 1; end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !sample_o && !capture_o && !res_valid_o, "R1", "idle outputs in reset",
        {busy_o, sample_o, capture_o, res_valid_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !res_valid_o, "R1", "idle after reset", {busy_o, res_valid_o}, 0);

    // minimum timing, eight steps: 120 cycles
    for (int i = 0; i < 8; i++) set_step(i, 7 - i, 0, 0, 1);
    run("R8", 7, -1, -1, -1, 0, 0);
    chk(busy_low == 120, "R6", "eight-step pass length", busy_low, 120);

    // mixed timing and averaging
    set_step(0, 2, 5, 3, 4);
    set_step(1, 5, 0, 0, 16);
    set_step(2, 1, 17, 1, 2);
    set_step(3, 7, 2, 9, 8);
    run("R8", 3, -1, -1, -1, 0, 0);

    // illegal averaging counts fall back to 1
    wr(0, 3, 3); wr(1, 3, 0); wr(2, 3, 17); wr(3, 3, 12);
    run("R7", 3, -1, -1, -1, 0, 0);
    set_step(4, 3, 0, 0, 32);
    run("R7", 4, -1, -1, -1, 0, 0);

    // continuous mode, dropped after several passes
    set_step(0, 4, 3, 2, 2);
    set_step(1, 6, 0, 5, 4);
    run("R10", 1, 200, -1, -1, 0, 0);
    run("R10", 0, 50, -1, -1, 0, 0);

    // write during a run: running step keeps old channel, later step takes new
    set_step(0, 1, 40, 0, 1);
    set_step(2, 3, 0, 0, 1);
    run("R2", 2, -1, -1, 10, 0, 6);
    run("R2", 2, -1, 20, 10, 2, 5);

    // start while busy is ignored, full-scale long step
    full_scale = 1;
    set_step(0, 7, 3000, 255, 16);
    run("R8", 0, -1, 100, -1, 0, 0);
    full_scale = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule